// File: doc/BRIEF.md
# Arcade Raster Timing Generator

This block produces horizontal and vertical raster timing for an arcade video system whose monitor is turned on its side. It runs from one master clock. The lowest horizontal bit toggles on every master clock, so the pixel rate is half the master rate. The other horizontal bits advance whenever that lowest bit is high. The horizontal count does not wrap to zero. It reloads a fixed odd value, which shortens each line to 382 counts. A matching vertical counter advances once per line, on the cycle where the horizontal sync falls, and its own reload gives 262 lines per frame.

Blanking and sync edges come from particular rising edges of counter bits. A set/clear flop captures each edge, so an edge changes its output only when the counter bit rises, never from a level alone. Downstream video logic uses the individual count bits together with the four timing strobes to fetch and serialise pixels.

Top module: `raster_timing_gen`

## Requirements
- R1: `h_bits[0]` (the pixel-rate bit) inverts on every clock edge out of reset. `h_bits[8:1]` advance by one only on edges where `h_bits[0]` was 1, except when they reload.
- R2: `h_bits` (bit 8 is the inverted 256 weight) counts 129, 130 … 510 and then returns to 129, giving a 382-cycle line.
- R3: `hblank` is 1 exactly for counts 144 to 239. It is set by the first rise of bit 4 after the reload, cleared by a rise of bit 4 while bits 5 and 6 are both 1, and held at 0 whenever bit 8 is 1.
- R4: Every line holds 96 cycles with `hblank` = 1 and 286 cycles with `hblank` = 0.
- R5: `hsync_n` is 0 exactly for counts 176 to 207 (32 cycles). It falls on the first rise of bit 4 after blanking starts, rises on a rise of bit 4 while bit 6 is 1, and is 1 whenever `hblank` is 0.
- R6: `v_bits` changes only on the edge where `hsync_n` goes from 1 to 0. It then advances by one through 249 … 510 and reloads 249, giving 262 lines per frame.
- R7: `vsync_n` is 0 exactly while `v_bits[8]` is 0, which covers counts 249 to 255 (the first 7 lines of the sequence).
- R8: `vblank` is 1 for counts 496 to 510 and 249 to 271 (38 lines) and 0 for counts 272 to 495 (224 lines). It rises on a bit-4 rise with bits 5 to 7 all 1, and falls on a bit-4 rise with bits 5 to 7 all 0 and bit 8 set.
- R9: A synchronous active-high `rst` loads `h_bits` = 129 and `v_bits` = 249, with `hblank` = 0, `hsync_n` = 1, `vblank` = 1 and `vsync_n` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (6 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| h_bits | output | 9 | Horizontal count; bit 0 is the pixel-rate bit, bit 8 the inverted 256 weight |
| v_bits | output | 9 | Vertical count; bit 0 is the line-rate bit |
| hblank | output | 1 | Horizontal blanking, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vblank | output | 1 | Vertical blanking, active high |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The only stimulus is the clock, plus reset. Each output is due on the same edge that moves the horizontal count to its new value. The vertical count and `vblank` change on the very edge where `hsync_n` falls (count 176), not one cycle later. Reset takes effect on the first edge where `rst` is high. The bench advances its own line and frame position on each rising edge. It compares every output at the following falling edge, so the expected position always includes the register update that edge made.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int HI_W  = 8;
  localparam int CNT_W = HI_W + 1;

  typedef logic [CNT_W-1:0] cnt_t;

  // bit positions the edge decoders depend on
  localparam int B16  = 4;
  localparam int B32  = 5;
  localparam int B64  = 6;
  localparam int B128 = 7;
  localparam int BTOP = 8;

  // rising edge of the 16-weight bit between this word and the next
  function automatic logic rise16(cnt_t cur, cnt_t nxt);
    return !cur[B16] && nxt[B16];
  endfunction

  // the top bit only drops at the reload
  function automatic logic h_reloaded(cnt_t cur, cnt_t nxt);
    return cur[BTOP] && !nxt[BTOP];
  endfunction

  function automatic logic h_blank_close(cnt_t cur, cnt_t nxt);
    return nxt[BTOP] || (rise16(cur, nxt) && nxt[B32] && nxt[B64]);
  endfunction

  function automatic logic h_sync_close(cnt_t cur, cnt_t nxt);
    return rise16(cur, nxt) && nxt[B64];
  endfunction

  function automatic logic v_blank_open(cnt_t cur, cnt_t nxt);
    return rise16(cur, nxt) && nxt[B32] && nxt[B64] && nxt[B128];
  endfunction

  function automatic logic v_blank_close(cnt_t cur, cnt_t nxt);
    return rise16(cur, nxt) && !nxt[B32] && !nxt[B64] && !nxt[B128] && nxt[BTOP];
  endfunction

endpackage

// File: rtl/raster_count.sv
// Pixel/line-rate bit toggles on every step; upper bits advance when it was
// high, and reload LOAD_HI once they reach all ones.
module raster_count #(
  parameter int                HI_W    = 8,
  parameter logic [HI_W-1:0]   LOAD_HI = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  output logic [HI_W:0]   cnt,
  output logic [HI_W:0]   nxt
);

  localparam logic [HI_W-1:0] HI_LAST = '1;

  logic            lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (step) begin
      lo_d = ~lo_q;
      if (hi_q == HI_LAST) begin
        hi_d = LOAD_HI;
      end else if (lo_q) begin
        hi_d = hi_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= 1'b1;
      hi_q <= LOAD_HI;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt = {hi_q, lo_q};
  assign nxt = {hi_d, lo_d};

endmodule

// File: rtl/raster_hdecode.sv
module raster_hdecode
  import raster_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cnt_t cur,
  input  cnt_t nxt,
  output logic hblank,
  output logic hsync_n,
  output logic sync_fall
);

  logic blank_arm_q, blank_arm_d;
  logic sync_arm_q,  sync_arm_d;
  logic blank_d, sync_n_d;
  logic edge16;

  assign edge16 = rise16(cur, nxt);

  always_comb begin
    blank_arm_d = blank_arm_q;
    if (edge16)              blank_arm_d = 1'b0;
    if (h_reloaded(cur, nxt)) blank_arm_d = 1'b1;

    blank_d = hblank;
    if (h_blank_close(cur, nxt))        blank_d = 1'b0;
    else if (edge16 && blank_arm_q)     blank_d = 1'b1;

    sync_arm_d = sync_arm_q;
    if (edge16 && sync_arm_q) sync_arm_d = 1'b0;
    if (!hblank && blank_d)   sync_arm_d = 1'b1;

    sync_n_d = hsync_n;
    if (!blank_d)                       sync_n_d = 1'b1;
    else if (h_sync_close(cur, nxt))    sync_n_d = 1'b1;
    else if (edge16 && sync_arm_q)      sync_n_d = 1'b0;
  end

  assign sync_fall = hsync_n && !sync_n_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hblank      <= 1'b0;
      hsync_n     <= 1'b1;
      blank_arm_q <= 1'b1;
      sync_arm_q  <= 1'b0;
    end else begin
      hblank      <= blank_d;
      hsync_n     <= sync_n_d;
      blank_arm_q <= blank_arm_d;
      sync_arm_q  <= sync_arm_d;
    end
  end

endmodule

// File: rtl/raster_vdecode.sv
module raster_vdecode
  import raster_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cnt_t cur,
  input  cnt_t nxt,
  output logic vblank
);

  logic blank_d;

  always_comb begin
    blank_d = vblank;
    if (v_blank_open(cur, nxt))       blank_d = 1'b1;
    else if (v_blank_close(cur, nxt)) blank_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) vblank <= 1'b1;
    else     vblank <= blank_d;
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter logic [HI_W-1:0] H_LOAD_HI = 8'h40,
  parameter logic [HI_W-1:0] V_LOAD_HI = 8'h7C
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] h_bits,
  output logic [CNT_W-1:0] v_bits,
  output logic             hblank,
  output logic             hsync_n,
  output logic             vblank,
  output logic             vsync_n
);

  cnt_t h_nxt, v_nxt;
  logic v_step;

  raster_count #(.HI_W(HI_W), .LOAD_HI(H_LOAD_HI)) u_hcnt (
    .clk (clk), .rst (rst), .step (1'b1),
    .cnt (h_bits), .nxt (h_nxt)
  );

  raster_hdecode u_hdec (
    .clk (clk), .rst (rst), .cur (h_bits), .nxt (h_nxt),
    .hblank (hblank), .hsync_n (hsync_n), .sync_fall (v_step)
  );

  raster_count #(.HI_W(HI_W), .LOAD_HI(V_LOAD_HI)) u_vcnt (
    .clk (clk), .rst (rst), .step (v_step),
    .cnt (v_bits), .nxt (v_nxt)
  );

  raster_vdecode u_vdec (
    .clk (clk), .rst (rst), .cur (v_bits), .nxt (v_nxt),
    .vblank (vblank)
  );

  assign vsync_n = v_bits[BTOP];

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk (
  input logic       clk,
  input logic       rst,
  input logic [8:0] hcnt,
  input logic [8:0] vcnt,
  input logic       hblank,
  input logic       hsync_n,
  input logic       vblank,
  input logic       vsync_n,
  input logic       v_step
);

  AST_H1_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> hcnt[0] != $past(hcnt[0])); // R1

  AST_H_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (hcnt == 9'd510) |=> (hcnt == 9'd129)); // R2

  AST_H_STEP: assert property (@(posedge clk) disable iff (rst)
    (hcnt != 9'd510) |=> (hcnt == $past(hcnt) + 9'd1)); // R2

  AST_HBLANK_TOP_LOW: assert property (@(posedge clk) disable iff (rst)
    hcnt[8] |-> !hblank); // R3

  AST_HSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> hblank); // R5

  AST_V_MOVE_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
    v_step |=> (!hsync_n && vcnt != $past(vcnt))); // R6

  AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
    !v_step |=> $stable(vcnt)); // R6

  AST_V_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (v_step && vcnt == 9'd510) |=> (vcnt == 9'd249)); // R6

  AST_VSYNC_IN_VBLANK: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> vblank); // R7

endmodule

bind raster_timing_gen raster_timing_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .hcnt    (h_bits),
  .vcnt    (v_bits),
  .hblank  (hblank),
  .hsync_n (hsync_n),
  .vblank  (vblank),
  .vsync_n (vsync_n),
  .v_step  (v_step)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

  localparam int LINE  = 382;
  localparam int FRAME = 262;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] h_bits, v_bits;
  logic       hblank, hsync_n, vblank, vsync_n;

  always #10 clk = ~clk;

  raster_timing_gen u_dut (
    .clk (clk), .rst (rst), .h_bits (h_bits), .v_bits (v_bits),
    .hblank (hblank), .hsync_n (hsync_n), .vblank (vblank), .vsync_n (vsync_n)
  );

  int  n_run  = 0;
  int  n_fail = 0;
  int  pos    = 0;   // position inside the line, 0 = count 129
  int  line   = 0;   // line inside the frame, 0 = count 249
  bit  done   = 1'b0;
  logic prev_h1;

  // bench model of where the raster is
  always @(posedge clk) begin
    if (rst) begin
      pos  = 0;
      line = 0;
    end else begin
      pos = (pos + 1) % LINE;
      if (pos == 47) line = (line + 1) % FRAME;  // count 176: sync falls
    end
  end

  function automatic logic [8:0] exp_h(int p);
    return 9'(129 + p);
  endfunction
  function automatic logic [8:0] exp_v(int l);
    return 9'(249 + l);
  endfunction
  function automatic logic exp_hblank(int p);
    return (129 + p >= 144) && (129 + p <= 239);
  endfunction
  function automatic logic exp_hsync_n(int p);
    return !((129 + p >= 176) && (129 + p <= 207));
  endfunction
  function automatic logic exp_vblank(int l);
    return (249 + l >= 496) || (249 + l <= 271);
  endfunction
  function automatic logic exp_vsync_n(int l);
    return (249 + l) >= 256;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (pos %0d line %0d)", tag, act, exp, pos, line);
    end
  endtask

  task automatic check_all();
    chk("R2 h_bits", int'(h_bits), int'(exp_h(pos)));
    chk("R3 hblank", int'(hblank), int'(exp_hblank(pos)));
    chk("R5 hsync_n", int'(hsync_n), int'(exp_hsync_n(pos)));
    chk("R6 v_bits", int'(v_bits), int'(exp_v(line)));
    chk("R7 vsync_n", int'(vsync_n), int'(exp_vsync_n(line)));
    chk("R8 vblank", int'(vblank), int'(exp_vblank(line)));
  endtask

  task automatic check_reset();
    chk("R9 reset h_bits", int'(h_bits), 129);
    chk("R9 reset v_bits", int'(v_bits), 249);
    chk("R9 reset hblank", int'(hblank), 0);
    chk("R9 reset hsync_n", int'(hsync_n), 1);
    chk("R9 reset vblank", int'(vblank), 1);
    chk("R9 reset vsync_n", int'(vsync_n), 0);
  endtask

  initial begin
    int hb_cnt, hs_cnt, vs_cnt, vb_cnt, vmoves, hsf_gap, hsf_last;
    logic [8:0] prev_v;
    logic prev_hs;
    void'($urandom(32'h5A17_C0DE));
    hb_cnt = 0; hs_cnt = 0; vs_cnt = 0; vb_cnt = 0; vmoves = 0;
    hsf_gap = 0; hsf_last = -1;

    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    prev_h1 = h_bits[0];
    prev_v  = v_bits;
    prev_hs = hsync_n;

    // one full frame with directed length measurements
    for (int k = 1; k <= LINE * FRAME; k++) begin
      @(negedge clk);
      check_all();
      if (h_bits[0] == prev_h1) chk("R1 pixel bit toggle", int'(h_bits[0]), int'(!prev_h1));
      prev_h1 = h_bits[0];
      if (hblank)   hb_cnt++;
      if (!hsync_n) hs_cnt++;
      if (!vsync_n) vs_cnt++;
      if (vblank)   vb_cnt++;
      if (v_bits != prev_v) begin
        vmoves++;
        if (!(prev_hs && !hsync_n)) chk("R6 v moves only on sync fall", 0, 1);
      end
      if (prev_hs && !hsync_n) begin
        if (hsf_last >= 0) hsf_gap = k - hsf_last;
        hsf_last = k;
      end
      prev_v  = v_bits;
      prev_hs = hsync_n;
    end
    chk("R4 blank cycles per frame", hb_cnt, 96 * FRAME);
    chk("R4 active cycles per frame", LINE * FRAME - hb_cnt, 286 * FRAME);
    chk("R5 sync-low cycles per frame", hs_cnt, 32 * FRAME);
    chk("R2 line length between sync falls", hsf_gap, LINE);
    chk("R6 lines per frame", vmoves, FRAME);
    chk("R7 vsync lines", vs_cnt, 7 * LINE);
    chk("R8 vblank lines", vb_cnt, 38 * LINE);

    // random run lengths with reset pulses dropped in at random points
    for (int r = 0; r < 6; r++) begin
      int run_len, rst_len;
      run_len = int'($urandom_range(3000, 500));
      rst_len = int'($urandom_range(4, 1));
      for (int k = 0; k < run_len; k++) begin
        @(negedge clk);
        check_all();
      end
      rst = 1'b1;
      repeat (rst_len) @(negedge clk);
      check_reset();
      rst = 1'b0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        check_all();
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule